// File: doc/BRIEF.md
# Multi-Codec Command Frame Serializer

This block sits on the controller side of a serial audio link. Up to four codecs share one frame-sync line, one serial data line and one bit clock. The block runs the link continuously in fixed 256-bit frames. Each frame opens with a 16-bit tag slot and is followed by twelve 20-bit slots. The block drives the frame-sync pulse and shifts each frame out most significant bit first. Each output changes on the rising edge of the bit clock.

A valid/ready request port takes one register command at a time. A command holds a 2-bit target identity (0 is the primary codec, 1 to 3 are secondaries), a read/write flag, a 7-bit register address and a 16-bit write value. The block holds one command in a pending stage. A command that is accepted before a frame begins goes out in that frame. At most one command is carried per frame.

Back-pressure works as follows. `req_ready` is low while a command waits in the pending stage. A requester must hold `req_valid` and the command fields steady until a clock edge where both `req_valid` and `req_ready` are high. The slot 0 encoding depends on the target. For the primary codec, the command-address and command-data tag bits mark what is valid. For a secondary codec, those tag bits are cleared and the target identity is carried in the low two tag bits.

Top module: `aclink_cmd_framer`

## Requirements
- R1: `sync` is high for the first 16 bit clocks of every frame and low for the remaining 240. Frames follow each other with no gap.
- R2: In clock cycle k of a frame (k = 0..255), `sdout` carries frame bit k. Frame bit 0 is slot 0 bit 15. Frame bit 16 is slot 1 bit 19. Frame bit 36 is slot 2 bit 19. Each slot goes out MSB first.
- R3: A frame that carries no command drives `sdout` low for all 256 bits.
- R4: A frame that carries a command has slot 0 bit 15 (frame valid) set.
- R5: For target identity 0, slot 0 bit 14 is 1 and slot 0 bits 1:0 are 00. Slot 0 bit 13 is 1 for a write and 0 for a read.
- R6: For target identity 1, 2 or 3, slot 0 bits 14 and 13 are 0 and slot 0 bits 1:0 equal the identity.
- R7: For a read, slot 1 bit 19 is 1, slot 1 bits 18:12 hold the address and slot 1 bits 11:0 are 0. All of slot 2 is 0.
- R8: For a write, slot 1 bit 19 is 0 and slot 1 bits 18:12 hold the address. Slot 2 bits 19:4 hold the data and slot 2 bits 3:0 are 0. Address and data go out in the same frame.
- R9: Slot 0 bits 12:2 are always 0. Slots 3 to 12 are always 0.
- R10: `req_ready` is high exactly when the pending stage is empty. An accepted command goes out in the first frame whose slot 0 starts at or after the accepting clock edge. This includes an acceptance on the last bit of a frame. Otherwise, `req_ready` falls on the cycle after the acceptance and rises again in bit 0 of the frame that carries the command.
- R11: `done` is high for exactly one cycle, during bit 255 of each frame that carries a command, and is low at all other times.
- R12: In the first cycle after reset, the block is in bit 0 of an idle frame: `sync` is 1, `sdout` is 0, `req_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Pending stage free; command taken when both valid and ready are high |
| req_id | input | 2 | Target identity, 0 = primary |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 7 | Register address |
| req_data | input | 16 | Write value (ignored for reads) |
| sync | output | 1 | Frame-sync pulse |
| sdout | output | 1 | Serial frame data |
| done | output | 1 | Last bit of a frame that carried a command |

## Verification
The bench uses the default geometry: a 16-bit tag slot and twelve 20-bit slots, giving a 256-bit frame. One frame is then short enough that the run covers idle frames, primary and secondary reads and writes for all four identities, and a burst of back-to-back requests that exercises back-pressure. It also covers a request accepted exactly on the last bit of a frame. The behavioural model builds each expected frame from the requirements and checks every output bit in every cycle.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int ID_W   = 2;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer #(
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] pos,
  output logic             frame_last,
  output logic             in_tag
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos <= '0;
    else if (frame_last) pos <= '0;
    else                 pos <= pos + 1'b1;
  end

  assign frame_last = (pos == LAST);
  assign in_tag     = (pos < CNT_W'(TAG_W));
endmodule

// File: rtl/aclink_cmd_stage.sv
module aclink_cmd_stage
  import aclink_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  cmd_t req_cmd,
  input  logic frame_last,
  output logic req_ready,
  output logic act_valid,
  output cmd_t act_cmd
);
  logic pend_valid;
  cmd_t pend_cmd;
  logic take;

  assign req_ready = !pend_valid;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_cmd   <= '0;
      act_valid  <= 1'b0;
      act_cmd    <= '0;
    end else if (frame_last) begin
      // frame boundary: pending (or a same-edge request) moves to the wire
      act_valid  <= pend_valid || take;
      act_cmd    <= pend_valid ? pend_cmd : req_cmd;
      pend_valid <= 1'b0;
    end else if (take) begin
      pend_valid <= 1'b1;
      pend_cmd   <= req_cmd;
    end
  end
endmodule

// File: rtl/aclink_slot_encoder.sv
module aclink_slot_encoder
  import aclink_pkg::*;
#(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int SLOT_COUNT = 12,
  localparam int FRAME_W   = TAG_W + SLOT_COUNT * SLOT_W,
  localparam int CNT_W     = $clog2(FRAME_W)
) (
  input  logic             act_valid,
  input  cmd_t             act_cmd,
  input  logic [CNT_W-1:0] pos,
  output logic             bit_out
);
  logic               primary;
  logic [TAG_W-1:0]   tag_w;
  logic [SLOT_W-1:0]  slot_w [SLOT_COUNT];
  logic [FRAME_W-1:0] frame_vec;

  assign primary = (act_cmd.id == '0);

  always_comb begin
    tag_w            = '0;
    tag_w[TAG_W-1]   = act_valid;
    tag_w[TAG_W-2]   = act_valid && primary;
    tag_w[TAG_W-3]   = act_valid && primary && act_cmd.write;
    tag_w[ID_W-1:0]  = act_valid ? act_cmd.id : '0;
  end

  assign frame_vec[FRAME_W-1 -: TAG_W] = tag_w;

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    if (s == 0) begin : g_addr
      assign slot_w[s] = act_valid
        ? {~act_cmd.write, act_cmd.addr, {(SLOT_W-1-ADDR_W){1'b0}}}
        : '0;
    end else if (s == 1) begin : g_data
      assign slot_w[s] = (act_valid && act_cmd.write)
        ? {act_cmd.data, {(SLOT_W-DATA_W){1'b0}}}
        : '0;
    end else begin : g_zero
      assign slot_w[s] = '0;
    end
    assign frame_vec[FRAME_W-1-TAG_W-s*SLOT_W -: SLOT_W] = slot_w[s];
  end

  assign bit_out = frame_vec[CNT_W'(FRAME_W-1) - pos];
endmodule

// File: rtl/aclink_cmd_framer.sv
module aclink_cmd_framer
  import aclink_pkg::*;
#(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int SLOT_COUNT = 12,
  localparam int FRAME_W   = TAG_BITS + SLOT_COUNT * SLOT_BITS,
  localparam int CNT_W     = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              sync,
  output logic              sdout,
  output logic              done
);
  logic [CNT_W-1:0] pos;
  logic             frame_last;
  logic             act_valid;
  cmd_t             act_cmd;
  cmd_t             req_cmd;

  assign req_cmd = '{id: req_id, write: req_write, addr: req_addr, data: req_data};

  aclink_bit_timer #(.FRAME_W(FRAME_W), .TAG_W(TAG_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .pos(pos), .frame_last(frame_last), .in_tag(sync)
  );

  aclink_cmd_stage u_stage (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .frame_last(frame_last), .req_ready(req_ready),
    .act_valid(act_valid), .act_cmd(act_cmd)
  );

  aclink_slot_encoder #(.TAG_W(TAG_BITS), .SLOT_W(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)) u_enc (
    .act_valid(act_valid), .act_cmd(act_cmd), .pos(pos), .bit_out(sdout)
  );

  assign done = act_valid && frame_last;
endmodule

// File: rtl/aclink_cmd_framer_chk.sv
module aclink_cmd_framer_chk #(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int SLOT_COUNT = 12,
  localparam int FRAME_W   = TAG_BITS + SLOT_COUNT * SLOT_BITS,
  localparam int CNT_W     = $clog2(FRAME_W)
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic sync,
  input logic sdout,
  input logic done
);
  // independent observer of frame position
  logic [CNT_W-1:0] c_pos;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             c_pos <= '0;
    else if (c_pos == CNT_W'(FRAME_W - 1))  c_pos <= '0;
    else                                    c_pos <= c_pos + 1'b1;
  end

  p_sync_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync == (c_pos < CNT_W'(TAG_BITS)));

  p_tail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pos >= CNT_W'(TAG_BITS + 2 * SLOT_BITS)) |-> !sdout);

  p_done_last_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (c_pos == CNT_W'(FRAME_W - 1)));

  p_done_then_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($rose(sync) && !done));

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && c_pos != CNT_W'(FRAME_W - 1)) |=> !req_ready);
endmodule

bind aclink_cmd_framer aclink_cmd_framer_chk #(
  .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sync(sync), .sdout(sdout), .done(done)
);

// File: tb/aclink_cmd_framer_test.sv
`timescale 1ns/1ps
module aclink_cmd_framer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_id = '0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic        sync, sdout, done;

  int n_vec = 0;
  int n_bad = 0;

  aclink_cmd_framer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .sync(sync), .sdout(sdout), .done(done)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  int          m_pos = 0;
  bit          m_pend_v = 0;
  logic [25:0] m_pend = '0;
  bit          m_act_v = 0;
  logic [25:0] m_act = '0;

  function automatic logic exp_bit(bit v, logic [25:0] c, int p);
    logic [255:0] f;
    logic [1:0] id = c[25:24];
    bit w = c[23];
    f = '0;
    if (v) begin
      f[255] = 1'b1;
      if (id == 2'd0) begin f[254] = 1'b1; f[253] = w; end
      f[241:240] = id;
      f[239] = !w;
      f[238:232] = c[22:16];
      if (w) f[219:204] = c[15:0];
    end
    return f[255-p];
  endfunction

  function automatic string bit_tag(bit v, logic [25:0] c, int p);
    if (!v) return "R3";
    if (p == 0) return "R4";
    if (p == 1 || p == 2 || p == 14 || p == 15) return (c[25:24] == 0) ? "R5" : "R6";
    if (p < 16) return "R9";
    if (p == 16) return "R2";
    if (p < 36) return c[23] ? "R8" : "R7";
    if (p < 56) return c[23] ? "R8" : "R7";
    return "R9";
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, m_pos, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_pend_v = 0; m_act_v = 0;
    end else begin
      bit acc;
      chk("R1", sync, m_pos < 16);
      chk(bit_tag(m_act_v, m_act, m_pos), sdout, exp_bit(m_act_v, m_act, m_pos));
      chk("R10", req_ready, !m_pend_v);
      chk("R11", done, m_act_v && m_pos == 255);
      acc = req_valid && !m_pend_v;
      if (m_pos == 255) begin
        m_act_v  = m_pend_v || acc;
        m_act    = m_pend_v ? m_pend : {req_id, req_write, req_addr, req_data};
        m_pend_v = 0;
      end else if (acc) begin
        m_pend_v = 1;
        m_pend   = {req_id, req_write, req_addr, req_data};
      end
      m_pos = (m_pos + 1) % 256;
    end
  end

  task automatic send(logic [1:0] id, bit w, logic [6:0] a, logic [15:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_id = id; req_write = w; req_addr = a; req_data = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: first cycle after reset
    n_vec++;
    if (!(sync === 1'b1 && sdout === 1'b0 && req_ready === 1'b1 && done === 1'b0)) begin
      n_bad++;
      $display("FAIL R12 actual=%b%b%b%b expected=1010", sync, sdout, req_ready, done);
    end
    repeat (300) @(posedge clk);                 // idle frames, R3
    send(2'd0, 1'b1, 7'h2a, 16'hbeef);            // primary write, R5 R8
    send(2'd0, 1'b0, 7'h7f, 16'hffff);            // primary read, R5 R7
    send(2'd1, 1'b0, 7'h01, 16'h1234);            // secondary reads, R6
    send(2'd2, 1'b0, 7'h40, 16'h0000);
    send(2'd3, 1'b1, 7'h55, 16'ha5a5);            // secondary write
    send(2'd2, 1'b1, 7'h00, 16'h8001);
    send(2'd1, 1'b1, 7'h3c, 16'h7ffe);
    // burst: back-pressure R10
    send(2'd3, 1'b0, 7'h11, 16'h0);
    send(2'd0, 1'b1, 7'h22, 16'h0f0f);
    send(2'd1, 1'b1, 7'h33, 16'hf0f0);
    repeat (800) @(posedge clk);
    // R10: acceptance on the last bit of a frame
    do begin @(posedge clk); #1; end while (m_pos != 255);
    req_valid = 1'b1; req_id = 2'd2; req_write = 1'b1; req_addr = 7'h6b; req_data = 16'hc3c3;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (600) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule